// File: doc/BRIEF.md
# Four-Channel Compare Timer with Watchdog

The block is a free-running 32-bit up-counter that advances on each timer tick and is watched by four compare channels. Each channel holds a compare value. When the counter equals that value on a tick, the channel's status flag is set and stays set until software clears it. Each flag can be routed to its own level-sensitive interrupt line through an enable bit. Channel 3 can also serve as a watchdog: once the watchdog is armed, a channel-3 match produces a one-cycle reset pulse. Software cannot disarm the watchdog.

All state is reached through a simple single-cycle register port. `reg_sel` is a word index, equal to the byte offset divided by four. A write takes effect at the next clock edge. A read returns data combinationally in the same cycle. The counter can be loaded at any time, and counting then continues upward from the loaded value.

Top module: `match_timer`

## Requirements
- R1: After reset, every register reads as zero. This covers the compare values, the counter, status, watchdog arm and interrupt enable. `irq` and `wdt_reset` are low.
- R2: The counter increases by one at each clock edge where `tick` is high. It holds its value when `tick` is low.
- R3: A write to index 4 loads the counter, and this takes priority over a tick in the same cycle. Counting continues upward from the loaded value. The counter wraps from 0xFFFFFFFF to 0.
- R4: The compare value of channel n (0 to 3) is written and read at index n.
- R5: When `tick` is high and the counter equals the compare value of channel n, status bit n (index 5, bits 3:0) is set at the next edge. It stays set while there are no clears, and the upper status bits read zero.
- R6: Writing status with bit n set to 1 clears flag n. Bits written as 0 leave their flags unchanged.
- R7: If a clear and a new match on the same channel occur in the same cycle, the flag stays set.
- R8: `irq[n]` is the registered AND of status bit n and interrupt-enable bit n. Interrupt enable is at index 7, bits 3:0. `irq[n]` appears one edge after the enable and the flag are both visible.
- R9: Clearing an interrupt-enable bit drops that interrupt line after one edge. The compare value and the status flag are left unchanged.
- R10: The watchdog arm bit (index 6, bit 0) is set by writing 1. Writing 0 does not clear it, and only reset clears it.
- R11: While the watchdog is armed, a channel-3 match drives `wdt_reset` high for exactly the following cycle. While the watchdog is not armed, `wdt_reset` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one pulse per timer tick |
| bus_en | input | 1 | Register access valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| irq | output | 4 | Per-channel level interrupt |
| wdt_reset | output | 1 | Watchdog reset pulse |

## Verification
The properties assume that `tick` and the bus inputs are synchronous to `clk` and stay stable for a whole cycle. They also assume that a write is recognised only when `bus_en` and `bus_we` are both high. The stimulus changes inputs just after the rising edge and issues one register access per cycle. It steers the counter onto chosen compare values, so every match happens on a known tick. Ticks are held low during read-back, so the counter value seen in a read is exact.

// File: rtl/match_timer.sv
module match_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [2:0]       reg_sel,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic [3:0]       irq,
  output logic             wdt_reset
);
  localparam int NCH = 4;
  localparam logic [2:0] SEL_CNT = 3'd4;
  localparam logic [2:0] SEL_STS = 3'd5;
  localparam logic [2:0] SEL_WDT = 3'd6;
  localparam logic [2:0] SEL_IER = 3'd7;

  logic [NCH-1:0][CNT_W-1:0] mr_q;
  logic [CNT_W-1:0]          cnt_q;
  logic [NCH-1:0]            sts_q, ier_q, hit, clr;
  logic                      wdt_en_q;

  wire wr = bus_en & bus_we;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign hit[n] = tick && (cnt_q == mr_q[n]);
    always_ff @(posedge clk) begin
      if (!rst_n)                             mr_q[n] <= '0;
      else if (wr && reg_sel == 3'(n))        mr_q[n] <= bus_wdata;
    end
  end

  assign clr = (wr && reg_sel == SEL_STS) ? bus_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      sts_q     <= '0;
      ier_q     <= '0;
      wdt_en_q  <= 1'b0;
      irq       <= '0;
      wdt_reset <= 1'b0;
    end else begin
      if (wr && reg_sel == SEL_CNT) cnt_q <= bus_wdata;
      else if (tick)                cnt_q <= cnt_q + 1'b1;
      sts_q     <= hit | (sts_q & ~clr);
      if (wr && reg_sel == SEL_IER) ier_q <= bus_wdata[NCH-1:0];
      wdt_en_q  <= wdt_en_q | (wr && reg_sel == SEL_WDT && bus_wdata[0]);
      irq       <= sts_q & ier_q;
      wdt_reset <= wdt_en_q & hit[NCH-1];
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_CNT: bus_rdata = cnt_q;
      SEL_STS: bus_rdata = {{(CNT_W-NCH){1'b0}}, sts_q};
      SEL_WDT: bus_rdata = {{(CNT_W-1){1'b0}}, wdt_en_q};
      SEL_IER: bus_rdata = {{(CNT_W-NCH){1'b0}}, ier_q};
      default: bus_rdata = mr_q[reg_sel[1:0]];
    endcase
  end
endmodule

module match_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick,
  input logic                  bus_en,
  input logic                  bus_we,
  input logic [2:0]            reg_sel,
  input logic [CNT_W-1:0]      cnt,
  input logic [3:0][CNT_W-1:0] mr,
  input logic [3:0]            sts,
  input logic [3:0]            ier,
  input logic                  wdt_en,
  input logic [3:0]            irq,
  input logic                  wdt_reset
);
  wire cnt_load = bus_en && bus_we && reg_sel == 3'd4;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_load) |=> cnt == $past(cnt) + 1'b1); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_load) |=> $stable(cnt)); // R2
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(sts & ier)); // R8
  AST_WDT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_en |=> wdt_en); // R10
  AST_WDT_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_en |=> !wdt_reset); // R11
  AST_WDT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == mr[3] && wdt_en) |=> wdt_reset); // R11

  for (genvar n = 0; n < 4; n++) begin : g_chk
    AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == mr[n]) |=> sts[n]); // R5
  end
endmodule

bind match_timer match_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_en(bus_en), .bus_we(bus_we),
  .reg_sel(reg_sel), .cnt(cnt_q), .mr(mr_q), .sts(sts_q), .ier(ier_q),
  .wdt_en(wdt_en_q), .irq(irq), .wdt_reset(wdt_reset)
);

// File: tb/sim_match_timer.sv
module sim_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;
  logic        wdt_reset;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int          kq[$];
  logic [31:0] eq[$];
  string       tq[$];

  match_timer u0 (.*);

  always #5 clk = ~clk;

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    kq.push_back(kind); eq.push_back(exp); tq.push_back(tag);
  endtask

  task automatic drive(input logic en, input logic we, input logic [2:0] sel,
                       input logic [31:0] d, input logic tk);
    @(posedge clk); #1;
    bus_en = en; bus_we = we; reg_sel = sel; bus_wdata = d; tick = tk;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d, input logic tk = 0);
    drive(1, 1, sel, d, tk);
  endtask

  task automatic rd(input logic [2:0] sel, input logic [31:0] exp, input string tag);
    drive(1, 0, sel, '0, 0);
    push(0, exp, tag);
  endtask

  task automatic step(input int n, input logic tk);
    for (int i = 0; i < n; i++) drive(0, 0, 3'd0, '0, tk);
  endtask

  always @(negedge clk) begin
    while (kq.size() > 0) begin
      int k; logic [31:0] e, a; string t;
      k = kq.pop_front(); e = eq.pop_front(); t = tq.pop_front();
      a = (k == 0) ? bus_rdata : (k == 1) ? {28'd0, irq} : {31'd0, wdt_reset};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int s = 0; s < 8; s++) rd(3'(s), 32'd0, "R1");
    push(1, 0, "R1"); push(2, 0, "R1");
    // R4 compare values
    wr(0, 32'h20); wr(1, 32'h40); wr(2, 32'h60); wr(3, 32'h80);
    rd(0, 32'h20, "R4"); rd(1, 32'h40, "R4"); rd(2, 32'h60, "R4"); rd(3, 32'h80, "R4");
    // R2 / R3 counting and load
    wr(4, 32'd100); rd(4, 32'd100, "R3");
    step(5, 1); rd(4, 32'd105, "R2");
    step(3, 0); rd(4, 32'd105, "R2");
    wr(4, 32'hFFFF_FFFE); step(3, 1); rd(4, 32'd1, "R3");
    wr(4, 32'h500, 1); rd(4, 32'h500, "R3");
    wr(5, 32'hF);
    // R5 match on channel 1
    wr(4, 32'h3E); step(2, 1); rd(5, 32'h0, "R5");
    step(1, 1); rd(5, 32'h2, "R5"); rd(4, 32'h41, "R5");
    step(3, 0); rd(5, 32'h2, "R5");
    // R8 interrupt gating
    wr(7, 32'h2); step(1, 0); push(1, 4'h0, "R8");
    step(1, 0); push(1, 4'h2, "R8");
    rd(7, 32'h2, "R8");
    // R9 disarm
    wr(7, 32'h0); step(1, 0); push(1, 4'h2, "R9");
    step(1, 0); push(1, 4'h0, "R9");
    rd(1, 32'h40, "R9"); rd(5, 32'h2, "R9");
    // R6 write-one-to-clear
    wr(5, 32'h0); rd(5, 32'h2, "R6");
    wr(5, 32'h2); rd(5, 32'h0, "R6");
    wr(4, 32'h20); step(1, 1); wr(4, 32'h40); step(1, 1);
    rd(5, 32'h3, "R6");
    wr(5, 32'h1); rd(5, 32'h2, "R6");
    wr(5, 32'hF); rd(5, 32'h0, "R6");
    // R7 match beats clear
    wr(4, 32'h40); wr(5, 32'h2, 1); rd(5, 32'h2, "R7");
    wr(5, 32'h2); rd(5, 32'h0, "R7");
    // R11 disarmed: no pulse
    wr(4, 32'h80); step(1, 1); step(1, 0); push(2, 0, "R11");
    rd(5, 32'h8, "R11"); wr(5, 32'hF);
    // R10 sticky arm
    wr(6, 32'h1); rd(6, 32'h1, "R10");
    wr(6, 32'h0); rd(6, 32'h1, "R10");
    // R11 armed pulse
    wr(4, 32'h80); step(1, 1);
    step(1, 0); push(2, 1, "R11");
    step(1, 0); push(2, 0, "R11");
    step(2, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule